// File: doc/BRIEF.md
# Periodic Event Interrupt Controller

This block turns timekeeping events into one active-high interrupt. Eight sources feed it: an alarm-match signal and seven calendar rollovers (tenths of a second, seconds, minutes, hours, days, weekdays, months). A software-visible enable mask picks which sources may interrupt. When an enabled source fires, its bit is latched in a pending register and the interrupt output rises.

Software reads the pending register to find out which sources fired. The read returns a snapshot taken when the read began. When the read strobe ends, only the bits that were reported are cleared. An event that arrives during the read, or in the cycle that clears the register, therefore stays pending and cannot be lost. The alarm input is a level meaning "match is valid", so it is edge-conditioned. The rollover inputs are one-cycle pulses.

Top module: `pic_periodic_irq`

## Requirements
- R1: Reset clears the enable mask and the pending register, and holds `irq_o` low. After reset, reads of both registers return 0x00.
- R2: A write with `cs_i`=1 and `wr_i`=1 at address 0x11 loads the enable mask from `wdata_i`. A read at 0x11 returns that mask. Any number of bits may be set together.
- R3: The pending and mask bit positions are: bit 0 alarm match, bit 1 tenths, bit 2 seconds, bit 3 minutes, bit 4 hours, bit 5 day, bit 6 weekday, bit 7 month. When a source fires while its mask bit is 1, its pending bit is set.
- R4: An event on a source whose mask bit is 0 sets no pending bit and does not raise `irq_o`.
- R5: `irq_o` is high in exactly the cycles in which at least one pending bit is set.
- R6: A read at 0x10 returns the pending bits as they stood when the read began. The value stays stable for as long as the read is held.
- R7: When a read at 0x10 ends, the reported bits are cleared. If no other bit is pending, `irq_o` drops in the following cycle.
- R8: An enabled event that arrives while a status read is active, or in the cycle where the read ends, stays pending and is returned by the next read.
- R9: The alarm input (bit 0) sets its pending bit only on a 0-to-1 transition. Holding it high does not set the bit again after a clearing read.
- R10: Writes to 0x10 or to any address other than 0x11, and any access with `cs_i`=0, change neither register. Reads at addresses other than 0x10 and 0x11 return 0x00.
- R11: Clearing a mask bit after its source has fired leaves the pending bit set until it is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 8 | Per-source events; bit 0 is an alarm-valid level, the other bits are one-cycle pulses |
| cs_i | input | 1 | Register port select |
| rd_i | input | 1 | Read strobe, held for the whole read |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 5 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data; 0 when no register is being read |
| irq_o | output | 1 | Interrupt output, active high |

## Verification
Some rules are checked by the assertions on every cycle:
- A pending bit only rises when its enable bit was set.
- Pending bits only fall at the end of a status read.
- Events in the clearing cycle survive.
- Read data holds steady through a status read.
- The mask changes only on a decoded write.

Other properties need the bench's scenarios:
- The exact bit-to-source mapping.
- The alarm level being seen only on its rising edge.
- Events arriving mid-read being returned by the next read.
- Writes to wrong addresses or without select leaving both registers untouched.

// File: rtl/pic_pkg.sv
package pic_pkg;
   localparam int unsigned PIC_DW    = 8;
   localparam int unsigned PIC_AW    = 5;
   localparam int unsigned PIC_NSRC  = 8;

   localparam logic [PIC_AW-1:0] PIC_STAT_ADDR = 5'h10;
   localparam logic [PIC_AW-1:0] PIC_MASK_ADDR = 5'h11;

   // source bit positions
   localparam int unsigned SRC_ALARM   = 0;
   localparam int unsigned SRC_TENTHS  = 1;
   localparam int unsigned SRC_SECOND  = 2;
   localparam int unsigned SRC_MINUTE  = 3;
   localparam int unsigned SRC_HOUR    = 4;
   localparam int unsigned SRC_DAY     = 5;
   localparam int unsigned SRC_WEEKDAY = 6;
   localparam int unsigned SRC_MONTH   = 7;

   typedef enum logic [1:0] {
      BUS_IDLE    = 2'd0,
      BUS_RD_STAT = 2'd1,
      BUS_RD_MASK = 2'd2,
      BUS_WR_MASK = 2'd3
   } bus_op_e;
endpackage

// File: rtl/pic_src_cond.sv
module pic_src_cond #(
   parameter int unsigned       N_SRC     = 8,
   parameter logic [N_SRC-1:0]  EDGE_MASK = 8'h01
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N_SRC-1:0] evt_i,
   output logic [N_SRC-1:0] hit_o
);
   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      if (EDGE_MASK[i]) begin : g_edge
         logic prev_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) prev_q <= 1'b0;
            else         prev_q <= evt_i[i];
         end
         assign hit_o[i] = evt_i[i] & ~prev_q;
      end else begin : g_pulse
         assign hit_o[i] = evt_i[i];
      end
   end
endmodule

// File: rtl/pic_bus_dec.sv
module pic_bus_dec
   import pic_pkg::*;
#(
   parameter int unsigned       AW        = 5,
   parameter logic [AW-1:0]     STAT_ADDR = 5'h10,
   parameter logic [AW-1:0]     MASK_ADDR = 5'h11
) (
   input  logic          cs_i,
   input  logic          rd_i,
   input  logic          wr_i,
   input  logic [AW-1:0] addr_i,
   output bus_op_e       op_o
);
   always_comb begin
      op_o = BUS_IDLE;
      if (cs_i && rd_i) begin
         if (addr_i == STAT_ADDR)      op_o = BUS_RD_STAT;
         else if (addr_i == MASK_ADDR) op_o = BUS_RD_MASK;
      end else if (cs_i && wr_i && addr_i == MASK_ADDR) begin
         op_o = BUS_WR_MASK;
      end
   end
endmodule

// File: rtl/pic_status.sv
module pic_status #(
   parameter int unsigned N_SRC = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N_SRC-1:0] set_i,
   input  logic             rsel_i,
   output logic [N_SRC-1:0] pend_o,
   output logic [N_SRC-1:0] snap_o,
   output logic             rsel_q_o
);
   logic [N_SRC-1:0] pend_q, snap_q, clr;
   logic             rsel_q, rd_start, rd_end;

   assign rd_start = rsel_i & ~rsel_q;
   assign rd_end   = ~rsel_i & rsel_q;
   assign clr      = rd_end ? snap_q : '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_q <= '0;
         snap_q <= '0;
         rsel_q <= 1'b0;
      end else begin
         // clear only what was reported; new sets always win
         pend_q <= (pend_q & ~clr) | set_i;
         rsel_q <= rsel_i;
         if (rd_start) snap_q <= pend_q;
      end
   end

   assign pend_o   = pend_q;
   assign snap_o   = snap_q;
   assign rsel_q_o = rsel_q;
endmodule

// File: rtl/pic_periodic_irq.sv
module pic_periodic_irq
   import pic_pkg::*;
#(
   parameter int unsigned       DW        = PIC_DW,
   parameter int unsigned       AW        = PIC_AW,
   parameter int unsigned       N_SRC     = PIC_NSRC,
   parameter logic [AW-1:0]     STAT_ADDR = PIC_STAT_ADDR,
   parameter logic [AW-1:0]     MASK_ADDR = PIC_MASK_ADDR,
   parameter logic [N_SRC-1:0]  EDGE_MASK = 8'h01
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N_SRC-1:0] evt_i,
   input  logic             cs_i,
   input  logic             rd_i,
   input  logic             wr_i,
   input  logic [AW-1:0]    addr_i,
   input  logic [DW-1:0]    wdata_i,
   output logic [DW-1:0]    rdata_o,
   output logic             irq_o
);
   if (N_SRC > DW) begin : g_chk_width
      $error("pic_periodic_irq: N_SRC exceeds data width");
   end
   if (STAT_ADDR == MASK_ADDR) begin : g_chk_addr
      $error("pic_periodic_irq: register addresses collide");
   end

   bus_op_e          op;
   logic [N_SRC-1:0] mask_q, hit, set, pend, snap;
   logic             rsel_q;

   pic_bus_dec #(
      .AW(AW), .STAT_ADDR(STAT_ADDR), .MASK_ADDR(MASK_ADDR)
   ) u_dec (
      .cs_i(cs_i), .rd_i(rd_i), .wr_i(wr_i), .addr_i(addr_i), .op_o(op)
   );

   pic_src_cond #(.N_SRC(N_SRC), .EDGE_MASK(EDGE_MASK)) u_cond (
      .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .hit_o(hit)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                mask_q <= '0;
      else if (op == BUS_WR_MASK) mask_q <= wdata_i[N_SRC-1:0];
   end

   assign set = hit & mask_q;

   pic_status #(.N_SRC(N_SRC)) u_stat (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set),
      .rsel_i(op == BUS_RD_STAT), .pend_o(pend), .snap_o(snap),
      .rsel_q_o(rsel_q)
   );

   always_comb begin
      rdata_o = '0;
      unique case (op)
         BUS_RD_STAT: rdata_o[N_SRC-1:0] = rsel_q ? snap : pend;
         BUS_RD_MASK: rdata_o[N_SRC-1:0] = mask_q;
         default:     rdata_o = '0;
      endcase
   end

   assign irq_o = |pend;
endmodule

// File: rtl/pic_periodic_irq_chk.sv
module pic_periodic_irq_chk #(
   parameter int unsigned N_SRC = 8,
   parameter int unsigned DW    = 8
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [N_SRC-1:0] mask,
   input logic [N_SRC-1:0] pend,
   input logic [N_SRC-1:0] set,
   input logic             stat_rd,
   input logic             mask_wr,
   input logic             rsel_q,
   input logic [DW-1:0]    rdata,
   input logic             irq
);
   // R4: a pending bit only rises while its enable was set
   for (genvar i = 0; i < N_SRC; i++) begin : g_en
      a_r4_set_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $rose(pend[i]) |-> $past(mask[i]));
   end

   // R7: pending bits fall only on the edge that ends a status read
   a_r7_clear_at_read_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|($past(pend) & ~pend)) |-> $past(rsel_q && !stat_rd));

   // R8: an event in the clearing cycle is kept
   a_r8_keep_late_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rsel_q && !stat_rd) |=> ((pend & $past(set)) == $past(set)));

   // R6: status read data holds while the read is held
   a_r6_stable_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_rd && $past(stat_rd)) |-> $stable(rdata));

   // R2: the mask changes only on a decoded write
   a_r2_mask_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(mask) |-> $past(mask_wr));

   // R5: the interrupt rises only after an enabled event
   a_r5_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq) |-> $past(|set));
endmodule

bind pic_periodic_irq pic_periodic_irq_chk #(.N_SRC(N_SRC), .DW(DW)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .mask(mask_q), .pend(pend), .set(set),
   .stat_rd(op == pic_pkg::BUS_RD_STAT), .mask_wr(op == pic_pkg::BUS_WR_MASK),
   .rsel_q(rsel_q), .rdata(rdata_o), .irq(irq_o)
);

// File: tb/sim_pic_periodic_irq.sv
`timescale 1ns/1ps
module sim_pic_periodic_irq;
   localparam logic [4:0] STAT = 5'h10;
   localparam logic [4:0] MASK = 5'h11;
   localparam int NV = 8;
   // {mask, event pulse, expected pending}
   localparam logic [23:0] VEC [NV] = '{
      {8'h01, 8'h01, 8'h01}, {8'h02, 8'h02, 8'h02}, {8'hFF, 8'h80, 8'h80},
      {8'h0F, 8'hF0, 8'h00}, {8'hF0, 8'hFF, 8'hF0}, {8'h00, 8'hFF, 8'h00},
      {8'hA5, 8'h3C, 8'h24}, {8'hFF, 8'hFF, 8'hFF}
   };

   logic       clk = 1'b0, rst_n = 1'b0;
   logic [7:0] evt = '0, wdata = '0, rdata;
   logic       cs = 1'b0, rd = 1'b0, wr = 1'b0, irq;
   logic [4:0] addr = '0;
   int         n_run = 0, n_fail = 0;
   logic       done = 1'b0;

   always #4 clk = ~clk;

   pic_periodic_irq u0 (
      .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .cs_i(cs), .rd_i(rd),
      .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [4:0] a, input logic [7:0] d, input logic sel = 1'b1);
      cs = sel; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      cs = 1'b0; wr = 1'b0;
   endtask

   // read held two cycles; mid event with start, tail event in clearing cycle
   task automatic rd_ev(input logic [4:0] a, input logic [7:0] mid,
                        input logic [7:0] tail, output logic [7:0] v);
      cs = 1'b1; rd = 1'b1; addr = a; evt = mid;
      @(negedge clk);
      evt = '0;
      @(negedge clk);
      v = rdata;
      cs = 1'b0; rd = 1'b0; evt = tail;
      @(negedge clk);
      evt = '0;
   endtask

   task automatic pulse(input logic [7:0] m);
      evt = m;
      @(negedge clk);
      evt = '0;
   endtask

   initial begin
      #(8ns * 200000);
      if (!done) begin
         check(1'b0, "watchdog", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] r;
      repeat (2) @(negedge clk);
      // R1 reset state
      check(irq == 1'b0, "R1 irq after reset", irq, 0);
      rst_n = 1'b1;
      @(negedge clk);
      rd_ev(MASK, 0, 0, r); check(r == 8'h00, "R1 mask after reset", r, 0);
      rd_ev(STAT, 0, 0, r); check(r == 8'h00, "R1 pending after reset", r, 0);

      // vector table: R2, R3, R4, R5, R6, R7
      for (int i = 0; i < NV; i++) begin
         logic [7:0] m, e, x;
         {m, e, x} = VEC[i];
         wr_reg(MASK, m);
         rd_ev(MASK, 0, 0, r); check(r == m, "R2 mask readback", r, m);
         pulse(e);
         check(irq == (x != 0), "R5 irq after event", irq, int'(x != 0));
         rd_ev(STAT, 0, 0, r); check(r == x, "R3/R4 pending bits", r, x);
         check(irq == 1'b0, "R7 irq cleared by read", irq, 0);
      end

      // R8: event mid-read and in the clearing cycle
      wr_reg(MASK, 8'hFF);
      pulse(8'h08);
      rd_ev(STAT, 8'h10, 8'h04, r);
      check(r == 8'h08, "R6 snapshot at read start", r, 8'h08);
      check(irq == 1'b1, "R8 irq kept by late events", irq, 1);
      rd_ev(STAT, 0, 0, r);
      check(r == 8'h14, "R8 late events still pending", r, 8'h14);

      // R9: alarm level fires on rise only
      evt[0] = 1'b1;
      @(negedge clk);
      cs = 1'b1; rd = 1'b1; addr = STAT;
      @(negedge clk); @(negedge clk);
      r = rdata; cs = 1'b0; rd = 1'b0;
      @(negedge clk);
      check(r == 8'h01, "R9 alarm rise sets bit", r, 1);
      cs = 1'b1; rd = 1'b1; addr = STAT;
      @(negedge clk); @(negedge clk);
      r = rdata; cs = 1'b0; rd = 1'b0;
      @(negedge clk);
      check(r == 8'h00, "R9 held alarm not re-set", r, 0);
      evt[0] = 1'b0;
      @(negedge clk);
      pulse(8'h01);
      rd_ev(STAT, 0, 0, r); check(r == 8'h01, "R9 alarm re-rise", r, 1);

      // R10: stray writes and reads
      wr_reg(MASK, 8'h3C);
      pulse(8'h04);
      wr_reg(STAT, 8'h00);
      wr_reg(5'h05, 8'hFF);
      wr_reg(MASK, 8'hC3, 1'b0);
      rd_ev(MASK, 0, 0, r); check(r == 8'h3C, "R10 mask untouched", r, 8'h3C);
      rd_ev(5'h03, 0, 0, r); check(r == 8'h00, "R10 unmapped read", r, 0);
      rd_ev(STAT, 0, 0, r); check(r == 8'h04, "R10 pending untouched", r, 8'h04);

      // R11: disabling keeps pending bit
      pulse(8'h20);
      wr_reg(MASK, 8'h00);
      check(irq == 1'b1, "R11 irq held after disable", irq, 1);
      rd_ev(STAT, 0, 0, r); check(r == 8'h20, "R11 pending kept", r, 8'h20);

      // R1: reset in the middle of activity
      wr_reg(MASK, 8'hFF);
      pulse(8'h40);
      rst_n = 1'b0;
      #1;
      check(irq == 1'b0, "R1 reset drops irq", irq, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd_ev(MASK, 0, 0, r); check(r == 8'h00, "R1 mask cleared", r, 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule